// File: doc/BRIEF.md
# Signed Bypass Decision Counter Table

This block learns, per requesting instruction, whether a missing block should skip the cache or be placed in it. It holds a large bank of small signed saturating counters selected by the low bits of the requesting program counter, plus a small bank with one counter per core that serves prefetch requests. A history structure elsewhere sends training events: a step down when the incoming block was reused before its victim, or a step up when the victim was reused first or the incoming block left unused.

On a miss the cache presents a lookup. One clock later the block returns a registered valid strobe and a one-bit decision: bypass when the selected counter is zero or positive, insert when it is negative. Training and lookup may arrive in the same cycle. A lookup always reads the counter as it was before that cycle's training step. There is no state machine: the block has only the counter state and the registered answer. Reset (synchronous, active high) returns every counter to -1, and the answer register to idle.

Top module: `bdct_top`

## Requirements
- R1: While `rst` is high at a clock edge, every counter returns to -1 and both `dec_valid` and `dec_bypass` read 0 after that edge, so the first lookup after reset returns insert.
- R2: A training event with `trn_up`=0 lowers the selected counter by 1. The counter stays at -8 (4-bit two's complement 1000) when already there.
- R3: A training event with `trn_up`=1 raises the selected counter by 1. The counter stays at +7 (0111) when already there.
- R4: A lookup returns `dec_bypass`=1 when the selected counter is 0 or more, and 0 when it is negative.
- R5: With the prefetch flag clear, training and lookup select the demand counter at index `trn_sig`/`lk_sig` (all 10 bits). Distinct indices never disturb each other.
- R6: With the prefetch flag set, training and lookup select the per-core counter numbered by `trn_core`/`lk_core`, and the signature is ignored. Prefetch training leaves the demand counters unchanged, and demand training leaves the prefetch counters unchanged.
- R7: When a lookup and a training event select the same counter in the same cycle, the lookup answers from the value before the update.
- R8: `dec_valid` is 1 exactly one cycle after a cycle with `lk_valid`=1. In cycles with no lookup answer, both `dec_valid` and `dec_bypass` are 0.
- R9: With `trn_valid`=0, no counter changes, whatever the other training inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| trn_valid | input | 1 | Training event present |
| trn_pf | input | 1 | Training event is for a prefetch request |
| trn_sig | input | 10 | Program-counter signature for demand training |
| trn_core | input | 2 | Core number for prefetch training |
| trn_up | input | 1 | 1 = raise counter, 0 = lower counter |
| lk_valid | input | 1 | Lookup request present |
| lk_pf | input | 1 | Lookup is for a prefetch request |
| lk_sig | input | 10 | Program-counter signature for demand lookup |
| lk_core | input | 2 | Core number for prefetch lookup |
| dec_valid | output | 1 | Decision valid, one cycle after the lookup |
| dec_bypass | output | 1 | 1 = bypass, 0 = insert |

## Verification
Repeated steps far past both limits, followed by a counted walk back, separate correct saturation from wrap-around or unbounded counting. The walk back ends where the sign flips only if the limit held. Single steps either side of zero pin down the bypass threshold at exactly 0. Lookups in the same cycle as training on the same counter show whether the answer was taken before or after the step. Training a prefetch counter and a demand counter that share the same low index bits, then reading both, shows whether the two banks are kept apart. A long stretch of mixed random traffic on a few hot indices is checked every cycle against a behavioural model. A reset partway through shows that the whole table returns to its initial state.

// File: rtl/bdct_pkg.sv
package bdct_pkg;
    // Direction of a training step
    typedef enum logic {
        STEP_DOWN = 1'b0,
        STEP_UP   = 1'b1
    } step_dir_e;
endpackage

// File: rtl/bdct_step.sv
// Saturating next-value logic for one signed counter
module bdct_step #(
    parameter int CNT_W = 4
) (
    input  logic signed [CNT_W-1:0] cur,
    input  bdct_pkg::step_dir_e     dir,
    output logic signed [CNT_W-1:0] nxt
);
    localparam logic signed [CNT_W-1:0] MAXV = {1'b0, {(CNT_W-1){1'b1}}};
    localparam logic signed [CNT_W-1:0] MINV = {1'b1, {(CNT_W-1){1'b0}}};
    localparam logic signed [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

    always_comb begin
        unique case (dir)
            bdct_pkg::STEP_UP:   nxt = (cur == MAXV) ? cur : cur + ONE;
            bdct_pkg::STEP_DOWN: nxt = (cur == MINV) ? cur : cur - ONE;
            default:             nxt = cur;
        endcase
    end
endmodule

// File: rtl/bdct_bank.sv
// Bank of signed saturating counters with one write and one read port
module bdct_bank #(
    parameter int N     = 1024,
    parameter int CNT_W = 4,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    we,
    input  logic [IDX_W-1:0]        wr_idx,
    input  logic                    wr_up,
    input  logic [IDX_W-1:0]        rd_idx,
    output logic signed [CNT_W-1:0] rd_val
);
    localparam logic signed [CNT_W-1:0] INITV = '1;
    localparam logic signed [CNT_W-1:0] MAXV  = {1'b0, {(CNT_W-1){1'b1}}};
    localparam logic signed [CNT_W-1:0] MINV  = {1'b1, {(CNT_W-1){1'b0}}};
    localparam logic signed [CNT_W-1:0] ONE   = {{(CNT_W-1){1'b0}}, 1'b1};
    localparam logic [IDX_W:0]          NLIM  = IDX_W'(N) == 0 && N > 1 ? {1'b1, {IDX_W{1'b0}}} : (IDX_W+1)'(N);

    logic signed [CNT_W-1:0] cnt [N];
    logic signed [CNT_W-1:0] wr_cur;
    logic signed [CNT_W-1:0] wr_nxt;
    logic                    wr_ok;
    logic                    rd_ok;
    bdct_pkg::step_dir_e     dir;

    assign wr_ok  = we && ({1'b0, wr_idx} < NLIM);
    assign rd_ok  = ({1'b0, rd_idx} < NLIM);
    assign wr_cur = wr_ok ? cnt[wr_idx] : INITV;
    assign rd_val = rd_ok ? cnt[rd_idx] : INITV;
    assign dir    = wr_up ? bdct_pkg::STEP_UP : bdct_pkg::STEP_DOWN;

    bdct_step #(.CNT_W(CNT_W)) u_step (
        .cur (wr_cur),
        .dir (dir),
        .nxt (wr_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) cnt[i] <= INITV;
        end else if (wr_ok) begin
            cnt[wr_idx] <= wr_nxt;
        end
    end

    // R3: a raise below the ceiling adds exactly one
    a_r3_raise: assert property (@(posedge clk) disable iff (rst)
        (wr_ok && wr_up && wr_cur != MAXV) |=> (cnt[$past(wr_idx)] == $past(wr_cur) + ONE));
    // R3: a raise at the ceiling holds it
    a_r3_ceiling: assert property (@(posedge clk) disable iff (rst)
        (wr_ok && wr_up && wr_cur == MAXV) |=> (cnt[$past(wr_idx)] == MAXV));
    // R2: a lower above the floor subtracts exactly one
    a_r2_lower: assert property (@(posedge clk) disable iff (rst)
        (wr_ok && !wr_up && wr_cur != MINV) |=> (cnt[$past(wr_idx)] == $past(wr_cur) - ONE));
    // R2: a lower at the floor holds it
    a_r2_floor: assert property (@(posedge clk) disable iff (rst)
        (wr_ok && !wr_up && wr_cur == MINV) |=> (cnt[$past(wr_idx)] == MINV));
endmodule

// File: rtl/bdct_top.sv
// Bypass decision table: demand bank indexed by signature, prefetch bank by core
module bdct_top #(
    parameter int SIG_W     = 10,
    parameter int CNT_W     = 4,
    parameter int NUM_CORES = 4,
    localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trn_valid,
    input  logic              trn_pf,
    input  logic [SIG_W-1:0]  trn_sig,
    input  logic [CORE_W-1:0] trn_core,
    input  logic              trn_up,
    input  logic              lk_valid,
    input  logic              lk_pf,
    input  logic [SIG_W-1:0]  lk_sig,
    input  logic [CORE_W-1:0] lk_core,
    output logic              dec_valid,
    output logic              dec_bypass
);
    localparam int DEM_N = 1 << SIG_W;

    logic signed [CNT_W-1:0] dem_val;
    logic signed [CNT_W-1:0] pf_val;
    logic signed [CNT_W-1:0] sel_val;
    logic                    dem_we;
    logic                    pf_we;

    assign dem_we = trn_valid && !trn_pf;
    assign pf_we  = trn_valid && trn_pf;

    bdct_bank #(.N(DEM_N), .CNT_W(CNT_W)) u_dem (
        .clk    (clk),
        .rst    (rst),
        .we     (dem_we),
        .wr_idx (trn_sig),
        .wr_up  (trn_up),
        .rd_idx (lk_sig),
        .rd_val (dem_val)
    );

    bdct_bank #(.N(NUM_CORES), .CNT_W(CNT_W)) u_pf (
        .clk    (clk),
        .rst    (rst),
        .we     (pf_we),
        .wr_idx (trn_core),
        .wr_up  (trn_up),
        .rd_idx (lk_core),
        .rd_val (pf_val)
    );

    assign sel_val = lk_pf ? pf_val : dem_val;

    // Registered answer; reads the pre-update counter value
    always_ff @(posedge clk) begin
        if (rst) begin
            dec_valid  <= 1'b0;
            dec_bypass <= 1'b0;
        end else begin
            dec_valid  <= lk_valid;
            dec_bypass <= lk_valid && !sel_val[CNT_W-1];
        end
    end

    // R1: reset leaves the answer idle
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (!dec_valid && !dec_bypass));
    // R8: a lookup is answered on the next cycle
    a_r8_answer: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> dec_valid);
    // R8: no lookup, no answer
    a_r8_quiet: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> (!dec_valid && !dec_bypass));
    // R4: bypass follows the sign of the selected counter
    a_r4_sign: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> (dec_bypass == !$past(sel_val[CNT_W-1])));
endmodule

// File: tb/bdct_top_bench.sv
module bdct_top_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       trn_valid = 1'b0, trn_pf = 1'b0, trn_up = 1'b0;
    logic [9:0] trn_sig = '0;
    logic [1:0] trn_core = '0;
    logic       lk_valid = 1'b0, lk_pf = 1'b0;
    logic [9:0] lk_sig = '0;
    logic [1:0] lk_core = '0;
    logic       dec_valid, dec_bypass;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit armed = 0;
    string cur_req = "R1";

    int dem [1024];
    int pfc [4];
    bit exp_v = 0;
    bit exp_b = 0;

    always #2 clk = ~clk;

    bdct_top u_bdct_top (
        .clk(clk), .rst(rst),
        .trn_valid(trn_valid), .trn_pf(trn_pf), .trn_sig(trn_sig),
        .trn_core(trn_core), .trn_up(trn_up),
        .lk_valid(lk_valid), .lk_pf(lk_pf), .lk_sig(lk_sig), .lk_core(lk_core),
        .dec_valid(dec_valid), .dec_bypass(dec_bypass)
    );

    // Behavioural reference model, advanced on every clock edge
    always @(posedge clk) begin
        int v;
        armed = 1;
        if (rst) begin
            foreach (dem[i]) dem[i] = -1;
            foreach (pfc[i]) pfc[i] = -1;
            exp_v = 0;
            exp_b = 0;
        end else begin
            v = lk_pf ? pfc[lk_core] : dem[lk_sig];
            exp_v = lk_valid;
            exp_b = lk_valid && (v >= 0);
            if (trn_valid) begin
                if (trn_pf) pfc[trn_core] = step(pfc[trn_core], trn_up);
                else        dem[trn_sig]  = step(dem[trn_sig], trn_up);
            end
        end
    end

    function automatic int step(int c, bit up);
        if (up) return (c >= 7) ? 7 : c + 1;
        return (c <= -8) ? -8 : c - 1;
    endfunction

    // Compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (armed) begin
            checks++;
            if (dec_valid !== exp_v || dec_bypass !== exp_b) begin
                failures++;
                $display("FAIL %s: valid/bypass actual=%b%b expected=%b%b at cycle %0d",
                         cur_req, dec_valid, dec_bypass, exp_v, exp_b, cycles);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            failures++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic cyc(bit tv, bit tpf, int tsig, int tcore, bit tup,
                       bit lv, bit lpf, int lsig, int lcore);
        trn_valid = tv; trn_pf = tpf; trn_sig = 10'(tsig); trn_core = 2'(tcore); trn_up = tup;
        lk_valid = lv; lk_pf = lpf; lk_sig = 10'(lsig); lk_core = 2'(lcore);
        @(negedge clk);
    endtask

    task automatic train(bit pf, int idx, bit up, int n);
        for (int k = 0; k < n; k++) cyc(1, pf, pf ? 0 : idx, pf ? idx : 0, up, 0, 0, 0, 0);
    endtask

    task automatic look(bit pf, int idx);
        cyc(0, 0, 0, 0, 0, 1, pf, pf ? 0 : idx, pf ? idx : 0);
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        @(negedge clk); @(negedge clk);
        rst = 0;
        cur_req = "R1"; look(0, 0); look(0, 1023); look(1, 3);
        cur_req = "R8"; cyc(0, 0, 0, 0, 0, 0, 0, 0, 0); look(0, 5);
        cur_req = "R4"; train(0, 9, 1, 1); look(0, 9); train(0, 9, 0, 1); look(0, 9);
        cur_req = "R3"; train(0, 20, 1, 10); look(0, 20); train(0, 20, 0, 8); look(0, 20);
        cur_req = "R2"; train(0, 21, 0, 10); look(0, 21); train(0, 21, 1, 8); look(0, 21);
        cur_req = "R5"; train(0, 512, 1, 3); look(0, 0); look(0, 512); look(0, 513);
        cur_req = "R6"; train(1, 2, 1, 3); look(1, 2); look(0, 2); look(1, 1);
        train(0, 1, 1, 4); look(1, 1); look(0, 1);
        cur_req = "R7";
        cyc(1, 0, 30, 0, 1, 1, 0, 30, 0);
        cyc(0, 0, 0, 0, 0, 1, 0, 30, 0);
        cyc(1, 0, 30, 0, 0, 1, 0, 30, 0);
        cyc(0, 0, 0, 0, 0, 1, 0, 30, 0);
        cur_req = "R9";
        for (int k = 0; k < 6; k++) cyc(0, 0, 40, 0, 1, 0, 0, 0, 0);
        look(0, 40);
        cur_req = "R1"; train(0, 50, 1, 5); rst = 1; @(negedge clk); rst = 0; look(0, 50); look(1, 2);
        cur_req = "R5";
        for (int k = 0; k < 4000; k++) begin
            int hot[6] = '{0, 1, 2, 512, 513, 1023};
            cyc($urandom_range(0, 1), $urandom_range(0, 1), hot[$urandom_range(0, 5)],
                $urandom_range(0, 3), $urandom_range(0, 1),
                $urandom_range(0, 1), $urandom_range(0, 1), hot[$urandom_range(0, 5)],
                $urandom_range(0, 3));
        end
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule